// File: doc/BRIEF.md
# Indirect Register Window for an Interrupt Redirection Table

This block is a small memory-mapped slave that gives software access to an interrupt controller's internal state through only two bus offsets. Software first writes a register index into a select register. It then reads or writes 32 bits through a data window, and that access reaches whichever internal register the index names.

The internal targets are:
- an identification register;
- a read-only version word;
- an arbitration word that mirrors the identification register;
- a table of 64-bit redirection entries, each reached as a low half and a high half through two consecutive indices.

The whole table is exported in parallel to a service engine. A one-cycle rescan strobe tells that engine when software has changed an entry. The remote-pending bit (bit 14) of every entry belongs to the service engine. Here it is only reflected, never stored.

Top module: `irq_regwin`

## Requirements
- R1: Bus offset 0x00 is the select register. A write of any size stores `req_wdata[7:0]`. A read returns the stored 8-bit value with bits [31:8] zero.
- R2: Every read request, whether a one-cycle `req_valid` with `req_write` low, produces `rd_valid` high for exactly the following cycle with `rd_data` registered. A read at any offset other than 0x00 and 0x10 returns zero.
- R3: Offset 0x10 is the data window. A window access with `req_size` other than 4 (bytes) is ignored. A write changes no state and raises no rescan, and a read returns zero.
- R4: A window write at index 0x00 stores `req_wdata[27:24]` as the 4-bit ID. Reading index 0x00 or index 0x02 returns the ID in bits [27:24] with all other bits zero.
- R5: Reading index 0x01 returns 0x11 in bits [7:0] and NUM_ENTRIES−1 in bits [23:16]. Window writes to index 0x01 or 0x02 change nothing.
- R6: For a select value s ≥ 0x10, the entry number is (s−0x10)>>1. An even s reaches entry bits [31:0] and an odd s reaches bits [63:32]. A write replaces only the addressed half, and `entries[64*n +: 64]` shows entry n.
- R7: A select value whose entry number is NUM_ENTRIES or more, or a value between 0x03 and 0x0F, reads as zero through the window. Writes at such a value change nothing and raise no rescan.
- R8: Every 4-byte window write that lands in a valid entry raises `rescan` for exactly the next cycle. No other access raises it.
- R9: Bit 14 of every entry is read-only. Window reads and `entries` show `remote_irr[n]` there, and the written value of bit 14 is discarded.
- R10: After reset the select register and ID are zero, and every entry reads 0x0000_0000_0001_0000 (only the mask bit 16 set) apart from bit 14, which follows `remote_irr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes |
| req_addr | input | 8 | Decoded low address byte |
| req_wdata | input | 32 | Write data |
| remote_irr | input | NUM_ENTRIES | Remote-pending bit per entry, from the service engine |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 32 | Registered read data |
| rescan | output | 1 | One-cycle request to rescan the table |
| entries | output | 64*NUM_ENTRIES | All table entries, entry n at [64n+63:64n] |

## Verification
The hardest case to reach is showing that a half write leaves the other half of the same entry intact. It is equally hard to show that the topmost legal index and the first illegal index behave differently. Both need a precise sequence of select writes followed by window accesses. The bench fills both halves of an entry with distinct patterns and then overwrites one half. It then checks the parallel `entries` output and a window read-back. It also steps the select value across the last valid entry and just past it.

// File: rtl/irq_regwin.sv
module irq_regwin #(
  parameter int NUM_ENTRIES = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [2:0]                req_size,
  input  logic [7:0]                req_addr,
  input  logic [31:0]               req_wdata,
  input  logic [NUM_ENTRIES-1:0]    remote_irr,
  output logic                      rd_valid,
  output logic [31:0]               rd_data,
  output logic                      rescan,
  output logic [64*NUM_ENTRIES-1:0] entries
);
  localparam logic [7:0] OFF_SEL  = 8'h00;
  localparam logic [7:0] OFF_WIN  = 8'h10;
  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] IDX_BASE = 8'h10;
  localparam int         IDX_W    = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [7:0] LAST_ENT = 8'(NUM_ENTRIES - 1);
  localparam logic [63:0] ENT_RST = 64'h0000_0000_0001_0000;
  localparam int         RIRR_BIT = 14;

  logic [7:0]  sel_q;
  logic [3:0]  id_q;
  logic [63:0] tbl_q [NUM_ENTRIES];
  logic [64*NUM_ENTRIES-1:0] tbl_flat;

  logic        sel_hit, win_hit, win_ok, wr_win;
  logic [7:0]  sel_off;
  logic [6:0]  ent_num;
  logic        in_tbl;
  logic [IDX_W-1:0] ent_idx;
  logic [63:0] cur_ent;
  logic [31:0] win_rdata, rd_next;

  assign sel_hit = req_valid && (req_addr == OFF_SEL);
  assign win_hit = req_valid && (req_addr == OFF_WIN);
  assign win_ok  = win_hit && (req_size == 3'd4);
  assign wr_win  = win_ok && req_write;

  assign sel_off = sel_q - IDX_BASE;
  assign ent_num = sel_off[7:1];
  assign in_tbl  = (sel_q >= IDX_BASE) && ({1'b0, ent_num} <= LAST_ENT);
  assign ent_idx = ent_num[IDX_W-1:0];

  always_comb begin
    cur_ent = in_tbl ? tbl_q[ent_idx] : 64'd0;
    if (in_tbl) cur_ent[RIRR_BIT] = remote_irr[ent_idx];
  end

  always_comb begin
    win_rdata = 32'd0;
    if (sel_q == IDX_ID || sel_q == IDX_ARB)
      win_rdata = {4'd0, id_q, 24'd0};
    else if (sel_q == IDX_VER)
      win_rdata = {8'd0, LAST_ENT, 8'd0, VERSION};
    else if (in_tbl)
      win_rdata = sel_q[0] ? cur_ent[63:32] : cur_ent[31:0];
  end

  always_comb begin
    rd_next = 32'd0;
    if (sel_hit)     rd_next = {24'd0, sel_q};
    else if (win_ok) rd_next = win_rdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q    <= '0;
      id_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rescan   <= 1'b0;
    end else begin
      rd_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rd_data <= rd_next;
      rescan <= wr_win && in_tbl;
      if (sel_hit && req_write) sel_q <= req_wdata[7:0];
      if (wr_win && sel_q == IDX_ID) id_q <= req_wdata[27:24];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) tbl_q[i] <= ENT_RST;
    end else if (wr_win && in_tbl) begin
      if (sel_q[0]) tbl_q[ent_idx][63:32] <= req_wdata;
      else          tbl_q[ent_idx][31:0]  <= {req_wdata[31:RIRR_BIT+1], 1'b0, req_wdata[RIRR_BIT-1:0]};
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_out
    assign tbl_flat[64*g +: 64] = tbl_q[g];
    assign entries[64*g +: 64] = {tbl_q[g][63:RIRR_BIT+1], remote_irr[g], tbl_q[g][RIRR_BIT-1:0]};
  end

  assert_rd_timing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(req_valid && !req_write));

  assert_odd_size_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && win_hit && req_size != 3'd4) |=> (rd_valid && rd_data == 32'd0));

  assert_odd_size_no_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_write && win_hit && req_size == 3'd4) |=> ($stable(tbl_flat) && $stable(id_q)));

  assert_rescan_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rescan |-> $past(req_valid && req_write && req_addr == OFF_WIN && req_size == 3'd4));

  assert_rirr_never_stored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_q[0][RIRR_BIT] == 1'b0);

  assert_ver_arb_no_id_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_win && (sel_q == IDX_VER || sel_q == IDX_ARB)) |=> $stable(id_q));
endmodule

// File: tb/test_irq_regwin.sv
module test_irq_regwin;
  localparam int N = 24;
  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [2:0] req_size = 0;
  logic [7:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [N-1:0] remote_irr = 0;
  logic rd_valid, rescan;
  logic [31:0] rd_data;
  logic [64*N-1:0] entries;
  int compared = 0, mismatched = 0;
  logic last_rescan;
  logic [31:0] rdv;

  always #4 clk = ~clk;

  irq_regwin #(.NUM_ENTRIES(N)) i_irq_regwin (
    .clk, .rst_n, .req_valid, .req_write, .req_size, .req_addr, .req_wdata,
    .remote_irr, .rd_valid, .rd_data, .rescan, .entries);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
    last_rescan = rescan;
  endtask

  task automatic rd(input logic [7:0] a, input logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; req_size = sz;
    @(negedge clk);
    req_valid = 0;
    chk("R2 rd_valid", {63'd0, rd_valid}, 64'd1);
    d = rd_data;
    @(negedge clk);
    chk("R2 rd_valid drop", {63'd0, rd_valid}, 64'd0);
  endtask

  task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
    wr(8'h00, 3'd1, {24'd0, s});
    rd(8'h10, 3'd4, d);
  endtask

  task automatic win_wr(input logic [7:0] s, input logic [31:0] d);
    wr(8'h00, 3'd1, {24'd0, s});
    wr(8'h10, 3'd4, d);
  endtask

  task automatic t_reset;
    rd(8'h00, 3'd4, rdv); chk("R10 select reset", rdv, 0);
    win_rd(8'h00, rdv);   chk("R10 id reset", rdv, 0);
    chk("R10 entry0", entries[63:0], 64'h0001_0000);
    chk("R10 entry last", entries[64*(N-1) +: 64], 64'h0001_0000);
    win_rd(8'h10, rdv);   chk("R10 entry0 low read", rdv, 32'h0001_0000);
  endtask

  task automatic t_select;
    wr(8'h00, 3'd2, 32'hFFFF_FF5A);
    rd(8'h00, 3'd4, rdv); chk("R1 select readback", rdv, 32'h5A);
    rd(8'h20, 3'd4, rdv); chk("R2 unmapped offset", rdv, 0);
  endtask

  task automatic t_id;
    win_wr(8'h00, 32'hF7FF_FFFF);
    chk("R8 no rescan id", {63'd0, last_rescan}, 0);
    win_rd(8'h00, rdv); chk("R4 id read", rdv, 32'h0700_0000);
    win_rd(8'h02, rdv); chk("R4 arb mirrors id", rdv, 32'h0700_0000);
  endtask

  task automatic t_version;
    win_rd(8'h01, rdv); chk("R5 version", rdv, 32'h0017_0011);
    win_wr(8'h01, 32'h0C00_0000);
    win_wr(8'h02, 32'h0C00_0000);
    win_rd(8'h00, rdv); chk("R5 ver/arb write ignored", rdv, 32'h0700_0000);
    win_rd(8'h01, rdv); chk("R5 version unchanged", rdv, 32'h0017_0011);
  endtask

  task automatic t_halves;
    win_wr(8'h1A, 32'h1234_0055);
    chk("R8 rescan low", {63'd0, last_rescan}, 1);
    @(negedge clk); chk("R8 rescan one cycle", {63'd0, rescan}, 0);
    win_wr(8'h1B, 32'hAB00_0000);
    chk("R8 rescan high", {63'd0, last_rescan}, 1);
    chk("R6 entry5 full", entries[64*5 +: 64], 64'hAB00_0000_1234_0055);
    win_wr(8'h1A, 32'h0000_00EE);
    chk("R6 half write keeps high", entries[64*5 +: 64], 64'hAB00_0000_0000_00EE);
    win_rd(8'h1B, rdv); chk("R6 high read", rdv, 32'hAB00_0000);
    chk("R6 neighbour untouched", entries[64*4 +: 64], 64'h0001_0000);
    win_wr(8'h3F, 32'hC0DE_0001);
    chk("R6 last entry high", entries[64*(N-1) +: 64], 64'hC0DE_0001_0001_0000);
    win_rd(8'h3F, rdv); chk("R6 last entry read", rdv, 32'hC0DE_0001);
  endtask

  task automatic t_range;
    win_wr(8'h40, 32'hFFFF_FFFF);
    chk("R7 no rescan out of range", {63'd0, last_rescan}, 0);
    win_rd(8'h40, rdv); chk("R7 out of range read", rdv, 0);
    win_rd(8'h0F, rdv); chk("R7 below base read", rdv, 0);
    chk("R7 last entry unchanged", entries[64*(N-1) +: 64], 64'hC0DE_0001_0001_0000);
  endtask

  task automatic t_size;
    wr(8'h00, 3'd4, 32'h1A);
    wr(8'h10, 3'd2, 32'h5555_5555);
    chk("R3 no rescan short write", {63'd0, last_rescan}, 0);
    chk("R3 short write ignored", entries[64*5 +: 64], 64'hAB00_0000_0000_00EE);
    rd(8'h10, 3'd1, rdv); chk("R3 short read zero", rdv, 0);
    rd(8'h10, 3'd4, rdv); chk("R3 full read", rdv, 32'h0000_00EE);
  endtask

  task automatic t_rirr;
    remote_irr[5] = 1'b1;
    win_rd(8'h1A, rdv); chk("R9 remote bit reflected", rdv, 32'h0000_40EE);
    chk("R9 entries bit14", {63'd0, entries[64*5+14]}, 1);
    remote_irr[5] = 1'b0;
    win_wr(8'h1A, 32'h0000_4001);
    win_rd(8'h1A, rdv); chk("R9 write of bit14 dropped", rdv, 32'h0000_0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_select; t_id; t_version; t_halves; t_range; t_size; t_rirr;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #400000;
    compared++; mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule